// File: doc/BRIEF.md
# Overlap-Aware Line Transfer Direction Planner

This block decides, once per rectangle transfer, whether each line can be copied in increasing address order or must be copied from its right end backwards. The decision depends on the direction and overlap flags and on how far the destination lies from the source. Distances are measured in quadwords of 64 bits plus a 6-bit offset inside the quadword. When a start is accepted, the block registers three things: the signed non-overlap distance, the chosen direction, and a page pre-touch indication.

After the decision, the block presents one chunk at a time to a downstream walker. Each chunk carries a source and destination start pointer, split into a 16-bit-word offset and a 6-bit bit pointer, and a bit count. A forward line is one chunk covering the whole width. A reversed line is cut into chunks no larger than the non-overlap distance, starting at the line end and moving back. The walker pulses a take input to consume a chunk. When the last chunk of a line is taken, the line counter drops by one and the next line starts again from its own end. Memory access, address stepping between lines and data combining are left to the walker.

Top module: `xfer_dir_planner`

## Requirements
- R1: While reset is low, and in the cycle after it, `busy`, `chunk_valid`, `plan_rtl` and `plan_touch` are 0 and `lines_left` is 0.
- R2: On an accepted start, `plan_gap` becomes 64*(dst_qword - src_qword) + (dst_bit - src_bit), two's complement in QW_W+7 bits. It is visible in the cycle after the start edge.
- R3: The flags are {flag_backward, flag_disjoint, flag_disjoint_items}. Unless they are exactly 1,0,0, `plan_rtl` and `plan_touch` are 0.
- R4: With flags 1,0,0, `plan_touch` is 1. `plan_rtl` is 1 exactly when all three of these hold: the gap is non-negative and at least 64, the width is at least 64, and the width is at least the gap.
- R5: When `plan_rtl` is 0, each line is one chunk. Its `chunk_bits` equals the width, its pointers equal the start bit offsets, and `chunk_last` is 1.
- R6: When `plan_rtl` is 1, each chunk moves n = min(gap, bits remaining) bits. The chunk pointers are the line-end pointer (start offset + width) minus n. After each take, the line-end pointer falls by n and the bits remaining fall by n. A chunk is held stable until it is taken.
- R7: `chunk_last` is 1 when n equals the bits remaining. Taking that chunk decrements `lines_left`, and the next line's first chunk starts again from start offset + width.
- R8: `busy` and `chunk_valid` fall when the last line's last chunk is taken. A start with zero height or zero width leaves `busy` at 0 and `lines_left` at 0.
- R9: A start while `busy` is 1 is ignored, and so is a take while `chunk_valid` is 0. In both cases the plan outputs, the chunk outputs and `lines_left` do not change.
- R10: Each pointer p is presented as a word offset p >> 4 and a bit pointer p mod 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin planning a transfer (accepted only when idle) |
| flag_backward | input | 1 | Transfer runs toward decreasing addresses |
| flag_disjoint | input | 1 | Source and destination rectangles do not overlap |
| flag_disjoint_items | input | 1 | Rectangles overlap but individual lines do not |
| src_qword | input | QW_W | Source quadword index |
| dst_qword | input | QW_W | Destination quadword index |
| src_bit | input | 6 | Source bit offset within the quadword |
| dst_bit | input | 6 | Destination bit offset within the quadword |
| width | input | WIDTH_W | Line width in bits |
| height | input | WIDTH_W | Number of lines |
| chunk_take | input | 1 | Walker consumes the presented chunk |
| busy | output | 1 | Lines remain to be planned |
| plan_rtl | output | 1 | Lines are copied right to left in chunks |
| plan_touch | output | 1 | Pages must be pre-touched |
| plan_gap | output | QW_W+7 | Signed non-overlap distance in bits |
| chunk_valid | output | 1 | A chunk is presented |
| chunk_src_word | output | WIDTH_W-3 | Source chunk pointer word offset |
| chunk_src_bit | output | 6 | Source chunk pointer bit position |
| chunk_dst_word | output | WIDTH_W-3 | Destination chunk pointer word offset |
| chunk_dst_bit | output | 6 | Destination chunk pointer bit position |
| chunk_bits | output | WIDTH_W | Bits moved by this chunk |
| chunk_last | output | 1 | Chunk is the last of its line |
| lines_left | output | WIDTH_W | Lines still to be completed |

## Verification
The bench builds the block with QW_W = 10 and WIDTH_W = 12. With 10-bit quadword indices, negative gaps and gaps above the width are reached cheaply. A 12-bit width lets lines of a few hundred bits break into several reversed chunks with a short final remainder. These values put the exact boundaries within a few cycles of each start: gap equal to 64, width equal to 64, and width equal to the gap. They also make it cheap to check a second line restarting from its end.

// File: rtl/xdp_pkg.sv
// Shared constants and types for the transfer direction planner.
// Assumes quadwords of 64 bits addressed by a 6-bit offset and 16-bit words.
package xdp_pkg;
    localparam int OFF_W      = 6;
    localparam int QW_BITS    = 64;
    localparam int WORD_SHIFT = 4;

    typedef struct packed {
        logic backward;
        logic disjoint;
        logic disjoint_items;
    } xfer_flags_t;
endpackage

// File: rtl/xdp_decide.sv
// Combinational direction decision for one transfer.
// Computes the signed non-overlap distance and chooses reversal only for a
// backward, overlapping transfer whose geometry makes a forward copy unsafe.
// Assumes GAP_W = QW_W + 7 so the scaled quadword difference cannot wrap.
module xdp_decide #(
    parameter int QW_W    = 16,
    parameter int WIDTH_W = 15
) (
    input  xdp_pkg::xfer_flags_t flags,
    input  logic [QW_W-1:0]      src_qw,
    input  logic [QW_W-1:0]      dst_qw,
    input  logic [5:0]           src_off,
    input  logic [5:0]           dst_off,
    input  logic [WIDTH_W-1:0]   width,
    output logic [QW_W+6:0]      gap,
    output logic                 rtl,
    output logic                 touch
);
    import xdp_pkg::*;
    localparam int GAP_W = QW_W + 7;

    logic [GAP_W-1:0] qdiff;
    logic [GAP_W-1:0] odiff;
    logic [GAP_W-1:0] width_ext;
    logic             cand;
    logic             gap_pos;
    logic             gap_big;
    logic             wide;
    logic             covers;

    // Distance and geometry tests in modular two's-complement arithmetic.
    always_comb begin
        qdiff     = GAP_W'(dst_qw) - GAP_W'(src_qw);
        odiff     = GAP_W'(dst_off) - GAP_W'(src_off);
        gap       = (qdiff << OFF_W) + odiff;
        width_ext = GAP_W'(width);
        cand      = flags.backward && !flags.disjoint && !flags.disjoint_items;
        gap_pos   = !gap[GAP_W-1];
        gap_big   = gap_pos && (gap >= GAP_W'(QW_BITS));
        wide      = width_ext >= GAP_W'(QW_BITS);
        covers    = gap_pos && (width_ext >= gap);
        rtl       = cand && gap_big && wide && covers;
        touch     = cand;
    end
endmodule

// File: rtl/xdp_chunker.sv
// Chunk sequencer for one line, shared by the source and destination tracks.
// Both tracks keep a line-end pointer; the presented chunk starts at that
// end minus the step, so a forward line (step = width) lands on the start.
// Assumes gap_bits <= width whenever rtl is set.
module xdp_chunker #(
    parameter int WIDTH_W = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [WIDTH_W-1:0]           load_width,
    input  logic [1:0][5:0]              load_off,
    input  logic                         rtl,
    input  logic [WIDTH_W-1:0]           gap_bits,
    input  logic                         advance,
    output logic [WIDTH_W-1:0]           step,
    output logic                         last,
    output logic [1:0][WIDTH_W-4:0]      word,
    output logic [1:0][5:0]              bitp
);
    import xdp_pkg::*;
    localparam int PTR_W = WIDTH_W + 1;

    logic [WIDTH_W-1:0] remaining;

    // Chunk size is the gap when reversing, bounded by what is left.
    always_comb begin
        step = (rtl && (gap_bits < remaining)) ? gap_bits : remaining;
        last = (step == remaining);
    end

    // Bits still to move on the current line.
    always_ff @(posedge clk) begin
        if (!rst_n)       remaining <= '0;
        else if (load)    remaining <= load_width;
        else if (advance) remaining <= remaining - step;
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_track
        logic [PTR_W-1:0] end_r;
        logic [PTR_W-1:0] ptr;

        // Line-end pointer of this track, pulled back by each taken chunk.
        always_ff @(posedge clk) begin
            if (!rst_n)       end_r <= '0;
            else if (load)    end_r <= PTR_W'(load_off[ch]) + PTR_W'(load_width);
            else if (advance) end_r <= end_r - PTR_W'(step);
        end

        // Chunk start pointer split into word offset and bit position.
        assign ptr      = end_r - PTR_W'(step);
        assign word[ch] = ptr[PTR_W-1:WORD_SHIFT];
        assign bitp[ch] = ptr[OFF_W-1:0];
    end
endmodule

// File: rtl/xfer_dir_planner.sv
// Top of the transfer direction planner.
// Registers the direction decision on an accepted start, counts lines, and
// presents chunks to a walker that consumes them with chunk_take.
// Assumes line-to-line address stepping is done by the walker.
module xfer_dir_planner #(
    parameter int QW_W    = 16,
    parameter int WIDTH_W = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 flag_backward,
    input  logic                 flag_disjoint,
    input  logic                 flag_disjoint_items,
    input  logic [QW_W-1:0]      src_qword,
    input  logic [QW_W-1:0]      dst_qword,
    input  logic [5:0]           src_bit,
    input  logic [5:0]           dst_bit,
    input  logic [WIDTH_W-1:0]   width,
    input  logic [WIDTH_W-1:0]   height,
    input  logic                 chunk_take,
    output logic                 busy,
    output logic                 plan_rtl,
    output logic                 plan_touch,
    output logic [QW_W+6:0]      plan_gap,
    output logic                 chunk_valid,
    output logic [WIDTH_W-4:0]   chunk_src_word,
    output logic [5:0]           chunk_src_bit,
    output logic [WIDTH_W-4:0]   chunk_dst_word,
    output logic [5:0]           chunk_dst_bit,
    output logic [WIDTH_W-1:0]   chunk_bits,
    output logic                 chunk_last,
    output logic [WIDTH_W-1:0]   lines_left
);
    import xdp_pkg::*;
    localparam int GAP_W = QW_W + 7;

    xfer_flags_t          flags_in;
    logic [GAP_W-1:0]     gap_d;
    logic                 rtl_d;
    logic                 touch_d;
    logic                 busy_q;
    logic                 rtl_q;
    logic                 touch_q;
    logic [GAP_W-1:0]     gap_q;
    logic [WIDTH_W-1:0]   width_q;
    logic [5:0]           soff_q;
    logic [5:0]           doff_q;
    logic [WIDTH_W-1:0]   lines_q;
    logic                 accept;
    logic                 adv;
    logic                 line_end;
    logic                 final_line;
    logic                 reload;
    logic [WIDTH_W-1:0]   ld_width;
    logic [1:0][5:0]      ld_off;
    logic [WIDTH_W-1:0]   step;
    logic                 last;
    logic [1:0][WIDTH_W-4:0] word;
    logic [1:0][5:0]      bitp;

    assign flags_in = '{backward: flag_backward, disjoint: flag_disjoint,
                        disjoint_items: flag_disjoint_items};

    xdp_decide #(.QW_W(QW_W), .WIDTH_W(WIDTH_W)) u_decide (
        .flags   (flags_in),
        .src_qw  (src_qword),
        .dst_qw  (dst_qword),
        .src_off (src_bit),
        .dst_off (dst_bit),
        .width   (width),
        .gap     (gap_d),
        .rtl     (rtl_d),
        .touch   (touch_d)
    );

    // Handshake qualifiers: start only when idle, take only when presenting.
    always_comb begin
        accept     = start && !busy_q;
        adv        = chunk_take && busy_q;
        line_end   = adv && last;
        final_line = line_end && (lines_q == WIDTH_W'(1));
        reload     = accept || (line_end && !final_line);
        ld_width   = accept ? width : width_q;
        ld_off     = accept ? {dst_bit, src_bit} : {doff_q, soff_q};
    end

    // Plan and line geometry captured on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtl_q   <= 1'b0;
            touch_q <= 1'b0;
            gap_q   <= '0;
            width_q <= '0;
            soff_q  <= '0;
            doff_q  <= '0;
        end else if (accept) begin
            rtl_q   <= rtl_d;
            touch_q <= touch_d;
            gap_q   <= gap_d;
            width_q <= width;
            soff_q  <= src_bit;
            doff_q  <= dst_bit;
        end
    end

    // Line counter and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            lines_q <= '0;
        end else if (accept) begin
            busy_q  <= (width != '0) && (height != '0);
            lines_q <= (width == '0) ? '0 : height;
        end else if (line_end) begin
            lines_q <= lines_q - WIDTH_W'(1);
            if (final_line) busy_q <= 1'b0;
        end
    end

    xdp_chunker #(.WIDTH_W(WIDTH_W)) u_chunker (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (reload),
        .load_width (ld_width),
        .load_off   (ld_off),
        .rtl        (rtl_q),
        .gap_bits   (gap_q[WIDTH_W-1:0]),
        .advance    (adv && !line_end),
        .step       (step),
        .last       (last),
        .word       (word),
        .bitp       (bitp)
    );

    assign busy           = busy_q;
    assign plan_rtl       = rtl_q;
    assign plan_touch     = touch_q;
    assign plan_gap       = gap_q;
    assign chunk_valid    = busy_q;
    assign chunk_src_word = word[0];
    assign chunk_src_bit  = bitp[0];
    assign chunk_dst_word = word[1];
    assign chunk_dst_bit  = bitp[1];
    assign chunk_bits     = step;
    assign chunk_last     = last;
    assign lines_left     = lines_q;
endmodule

// File: rtl/xdp_checker.sv
// Protocol and plan checker for the transfer direction planner.
// Observes only top-level ports; attached by bind below.
module xdp_checker #(
    parameter int QW_W    = 16,
    parameter int WIDTH_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               plan_rtl,
    input logic               plan_touch,
    input logic [QW_W+6:0]    plan_gap,
    input logic               chunk_valid,
    input logic               chunk_take,
    input logic [5:0]         chunk_src_bit,
    input logic [5:0]         chunk_dst_bit,
    input logic [WIDTH_W-1:0] chunk_bits,
    input logic               chunk_last,
    input logic [WIDTH_W-1:0] lines_left
);
    localparam int GAP_W = QW_W + 7;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !chunk_valid && !plan_rtl && !plan_touch && lines_left == '0));

    // R3
    touch_with_rtl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plan_rtl |-> plan_touch);

    // R4
    rtl_geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plan_rtl |-> (!plan_gap[GAP_W-1] && plan_gap >= GAP_W'(64)));

    // R5
    ltr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && !plan_rtl) |-> chunk_last);

    // R6
    chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && plan_rtl) |-> (GAP_W'(chunk_bits) <= plan_gap && chunk_bits != '0));

    // R6
    chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && !chunk_take) |=>
            ($stable(chunk_bits) && $stable(chunk_src_bit) && $stable(chunk_dst_bit)));

    // R7
    line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && chunk_take && chunk_last) |=>
            (lines_left == $past(lines_left) - WIDTH_W'(1)));

    // R8
    idle_no_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (lines_left != '0));

    // R9
    plan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(plan_gap) && $stable(plan_rtl) && $stable(plan_touch)));
endmodule

bind xfer_dir_planner xdp_checker #(.QW_W(QW_W), .WIDTH_W(WIDTH_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .plan_rtl      (plan_rtl),
    .plan_touch    (plan_touch),
    .plan_gap      (plan_gap),
    .chunk_valid   (chunk_valid),
    .chunk_take    (chunk_take),
    .chunk_src_bit (chunk_src_bit),
    .chunk_dst_bit (chunk_dst_bit),
    .chunk_bits    (chunk_bits),
    .chunk_last    (chunk_last),
    .lines_left    (lines_left)
);

// File: tb/sim_xfer_dir_planner.sv
`timescale 1ns/1ps
module sim_xfer_dir_planner;
    localparam int QW_W    = 10;
    localparam int WIDTH_W = 12;
    localparam int GAP_W   = QW_W + 7;
    localparam int NV      = 11;

    // Fields, MSB first: flags{backward,disjoint,disjoint_items}[3], src_qword[10],
    // dst_qword[10], src_bit[6], dst_bit[6], width[12], height[4],
    // exp_rtl[1], exp_touch[1], exp_gap[18] two's complement.
    localparam logic [70:0] TBL [0:NV-1] = '{
        {3'b100, 10'd10, 10'd12, 6'd5, 6'd9,  12'd300, 4'd2, 1'b1, 1'b1, 18'd132},
        {3'b100, 10'd5,  10'd5,  6'd0, 6'd40, 12'd200, 4'd1, 1'b0, 1'b1, 18'd40},
        {3'b100, 10'd3,  10'd4,  6'd0, 6'd10, 12'd50,  4'd1, 1'b0, 1'b1, 18'd74},
        {3'b100, 10'd0,  10'd5,  6'd0, 6'd0,  12'd200, 4'd1, 1'b0, 1'b1, 18'd320},
        {3'b110, 10'd10, 10'd12, 6'd5, 6'd9,  12'd300, 4'd1, 1'b0, 1'b0, 18'd132},
        {3'b101, 10'd10, 10'd12, 6'd5, 6'd9,  12'd300, 4'd1, 1'b0, 1'b0, 18'd132},
        {3'b000, 10'd10, 10'd12, 6'd5, 6'd9,  12'd300, 4'd1, 1'b0, 1'b0, 18'd132},
        {3'b100, 10'd9,  10'd7,  6'd3, 6'd1,  12'd100, 4'd1, 1'b0, 1'b1, 18'h3FF7E}, // -130
        {3'b100, 10'd1,  10'd2,  6'd7, 6'd7,  12'd64,  4'd3, 1'b1, 1'b1, 18'd64},
        {3'b100, 10'd0,  10'd1,  6'd0, 6'd36, 12'd100, 4'd1, 1'b1, 1'b1, 18'd100},
        {3'b100, 10'd0,  10'd1,  6'd0, 6'd36, 12'd99,  4'd1, 1'b0, 1'b1, 18'd100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic f_bw = 1'b0, f_dj = 1'b0, f_di = 1'b0;
    logic [QW_W-1:0] sq = '0, dq = '0;
    logic [5:0] sb = '0, db = '0;
    logic [WIDTH_W-1:0] wd = '0, ht = '0;
    logic take = 1'b0;
    logic busy, p_rtl, p_touch, c_valid, c_last;
    logic [GAP_W-1:0] p_gap;
    logic [WIDTH_W-4:0] c_sw, c_dw;
    logic [5:0] c_sb, c_db;
    logic [WIDTH_W-1:0] c_bits, l_left;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xfer_dir_planner #(.QW_W(QW_W), .WIDTH_W(WIDTH_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .flag_backward(f_bw), .flag_disjoint(f_dj), .flag_disjoint_items(f_di),
        .src_qword(sq), .dst_qword(dq), .src_bit(sb), .dst_bit(db),
        .width(wd), .height(ht), .chunk_take(take),
        .busy(busy), .plan_rtl(p_rtl), .plan_touch(p_touch), .plan_gap(p_gap),
        .chunk_valid(c_valid), .chunk_src_word(c_sw), .chunk_src_bit(c_sb),
        .chunk_dst_word(c_dw), .chunk_dst_bit(c_db), .chunk_bits(c_bits),
        .chunk_last(c_last), .lines_left(l_left)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_inputs(input logic [70:0] v);
        {f_bw, f_dj, f_di} = v[70:68];
        sq = v[67:58];
        dq = v[57:48];
        sb = v[47:42];
        db = v[41:36];
        wd = v[35:24];
        ht = WIDTH_W'(v[23:20]);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_take();
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
    endtask

    // Walk every chunk of every line and compare with the requirement model.
    task automatic walk(input int s_off, input int d_off, input int w, input int h,
                        input bit rtl, input int gap);
        for (int ln = 0; ln < h; ln++) begin
            int rem = w;
            int se = s_off + w;
            int de = d_off + w;
            int guard = 0;
            while (rem > 0 && guard < 64) begin
                int n = (rtl && gap < rem) ? gap : rem;
                int sp = se - n;
                int dp = de - n;
                string tg = rtl ? "R6" : "R5";
                chk(tg, int'(c_valid), 1);
                chk(tg, int'(c_bits), n);
                chk("R10 src word", int'(c_sw), sp >> 4);
                chk("R10 src bit", int'(c_sb), sp % 64);
                chk("R10 dst word", int'(c_dw), dp >> 4);
                chk("R10 dst bit", int'(c_db), dp % 64);
                chk("R7 last", int'(c_last), (n == rem) ? 1 : 0);
                chk("R7 lines", int'(l_left), h - ln);
                pulse_take();
                rem -= n; se -= n; de -= n;
                guard++;
            end
        end
        chk("R8 busy end", int'(busy), 0);
        chk("R8 valid end", int'(c_valid), 0);
        chk("R8 lines end", int'(l_left), 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        chk("R1 busy", int'(busy), 0);
        chk("R1 valid", int'(c_valid), 0);
        chk("R1 rtl", int'(p_rtl), 0);
        chk("R1 touch", int'(p_touch), 0);
        chk("R1 lines", int'(l_left), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: take while idle changes nothing
        pulse_take();
        chk("R9 idle take busy", int'(busy), 0);
        chk("R9 idle take lines", int'(l_left), 0);

        // Table of vectors: R2 R3 R4 plan, then R5 R6 R7 R10 walk
        for (int i = 0; i < NV; i++) begin
            logic [70:0] v = TBL[i];
            set_inputs(v);
            pulse_start();
            chk("R2 gap", int'($signed(p_gap)), int'($signed(v[17:0])));
            chk("R3 R4 rtl", int'(p_rtl), int'(v[19]));
            chk("R3 R4 touch", int'(p_touch), int'(v[18]));
            chk("R8 busy", int'(busy), 1);
            walk(int'(v[47:42]), int'(v[41:36]), int'(v[35:24]), int'(v[23:20]),
                 v[19], int'(v[17:0]));
        end

        // R9: start while busy is ignored
        set_inputs(TBL[0]);
        pulse_start();
        set_inputs(TBL[6]);
        ht = 12'd7;
        pulse_start();
        chk("R9 gap held", int'(p_gap), 132);
        chk("R9 rtl held", int'(p_rtl), 1);
        chk("R9 bits held", int'(c_bits), 132);
        chk("R9 src bit held", int'(c_sb), 173 % 64);
        chk("R9 lines held", int'(l_left), 2);
        walk(5, 9, 300, 2, 1'b1, 132);

        // R8: zero height
        set_inputs(TBL[1]);
        ht = '0;
        pulse_start();
        chk("R8 zero height busy", int'(busy), 0);
        chk("R8 zero height lines", int'(l_left), 0);
        chk("R4 zero height touch", int'(p_touch), 1);

        // R8: zero width
        set_inputs(TBL[1]);
        wd = '0;
        ht = 12'd3;
        pulse_start();
        chk("R8 zero width busy", int'(busy), 0);
        chk("R8 zero width lines", int'(l_left), 0);

        // R1: reset in the middle of a transfer
        set_inputs(TBL[0]);
        pulse_start();
        pulse_take();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid busy", int'(busy), 0);
        chk("R1 mid rtl", int'(p_rtl), 0);
        chk("R1 mid lines", int'(l_left), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule